// File: doc/BRIEF.md
# Descriptor-Ring DMA Channel

This block is one DMA channel that works through a circular ring of descriptors held in a memory reached by a simple synchronous port. Every descriptor is two 64-bit words. Software places descriptors in the ring, then writes a head index into a register to tell the channel how far the ring is filled. The channel fetches and runs each descriptor from its own tail index up to that head. After each one it advances the tail, which software reads to learn which descriptors have finished.

There are two kinds of descriptor. A copy descriptor moves a block of 64-bit words from a source address to a destination address, one word for each memory access. A status descriptor writes one 64-bit value to an address and may raise a level interrupt. An unknown descriptor kind stops the channel. Writing the head register twice in a row with the same value is flagged as a ring overrun.

Software reaches the channel through a small register port. Reads from it are combinational. Writes to it take effect on the next clock edge.

Top module: `dma_ring_channel`

## Requirements
- R1: After reset the head and tail read as 0, the error and status registers read as 0, and `irq` is low.
- R2: Slot i of the ring occupies memory words BASE+2*i (the first word) and BASE+2*i+1 (the second word). BASE is the word address written to register offset 2. The first word is fetched before the second.
- R3: A descriptor whose second word has bits 63:60 equal to 1 is a copy. Bits 63:46 of the first word hold the length in 64-byte units, so one unit is eight words. Bits 45:0 of the first word hold the source byte address, and bits 45:0 of the second word hold the destination byte address. The copy moves length*8 words in ascending order from word address source/8 to word address destination/8, and no word beyond them is written.
- R4: A copy with a length of 0 writes no memory, and the tail still advances past it.
- R5: A descriptor whose second word has bits 63:60 equal to 2 is a status descriptor. It makes exactly one write: the whole first word, to word address destination/8.
- R6: The channel runs descriptors in ring order while the tail differs from the head, and stops when they are equal. The tail goes up by one after each completed descriptor and wraps from the last slot to 0.
- R7: A status descriptor with bit 59 of its second word set drives `irq` high once it completes. `irq` stays high until software writes a 1 to bit 2 of the status register (offset 4). A status descriptor with bit 59 clear leaves `irq` unchanged.
- R8: Writing the head register (offset 0) with the same value as the previous head write sets error bit 0 (offset 3). The bit stays set until reset. The first head write after reset is never flagged.
- R9: Any other descriptor kind sets error bit 1 and halts the channel. While halted the channel makes no memory access and does not advance the tail, and the status register shows quiesce in bit 1.
- R10: Register offsets are: 0 head (read and write), 1 tail (read), 2 ring base (read and write), 3 error, 4 status. In the status register, bit 0 is busy, bit 1 is quiesce, bit 2 is the interrupt level, and writing bit 2 acknowledges the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable (0 means read) |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid the cycle after a read request |
| irq | output | 1 | Level interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- the tail moves only by a single step when a descriptor completes;
- the overrun error bit stays set once it is set;
- `irq` stays high until it is acknowledged and rises only when a flagged status descriptor completes;
- a halted channel stays halted and makes no memory access.

Other behaviours can only be shown by the bench scenarios:
- what a copy or status descriptor puts in memory;
- that a copy with a length of 0 writes nothing;
- the slot addressing relative to the ring base;
- the wrap of the tail after a batch of descriptors;
- how the error bits are decoded.

// File: rtl/dma_ring_pkg.sv
// Shared constants and types for the descriptor-ring DMA channel.
// Assumes descriptors are two 64-bit words. The kind code is in bits 63:60 of the second word.
package dma_ring_pkg;
    localparam int KIND_LSB = 60;
    localparam int IRQ_BIT  = 59;
    localparam int LEN_LSB  = 46;

    localparam logic [3:0] KIND_COPY = 4'd1;
    localparam logic [3:0] KIND_STAT = 4'd2;

    localparam logic [2:0] RA_HEAD = 3'd0;
    localparam logic [2:0] RA_TAIL = 3'd1;
    localparam logic [2:0] RA_BASE = 3'd2;
    localparam logic [2:0] RA_ERR  = 3'd3;
    localparam logic [2:0] RA_STAT = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD1, ST_DEC, ST_CP_RD, ST_CP_WR, ST_ST_WR, ST_DONE, ST_HALT
    } eng_state_t;
endpackage

// File: rtl/dma_ring_tail.sv
// Tail index of the ring, plus the word address of the slot it points at.
// Assumes the engine pulses done_i once for each completed descriptor.
module dma_ring_tail #(
    parameter int IDX_W  = 3,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [MEM_AW-1:0] base_i,
    output logic [IDX_W-1:0]  tail_o,
    output logic [MEM_AW-1:0] slot_addr_o
);
    logic [IDX_W-1:0] tail_q;

    // Step the tail by one on each completion. The wrap is modulo 2**IDX_W.
    always_ff @(posedge clk) begin
        if (!rst_n) tail_q <= '0;
        else if (done_i) tail_q <= tail_q + 1'b1;
    end

    assign tail_o      = tail_q;
    assign slot_addr_o = base_i + MEM_AW'({tail_q, 1'b0});

    // R6: the tail moves one step on a completion and holds otherwise
    a_r6_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> tail_q == IDX_W'($past(tail_q) + 1'b1));
    a_r6_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(tail_q));
endmodule

// File: rtl/dma_ring_regs.sv
// Software register file: head, ring base, error bits, interrupt level.
// Assumes one register write per cycle. Reads are combinational.
module dma_ring_regs
    import dma_ring_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [IDX_W-1:0]  tail_i,
    input  logic              busy_i,
    input  logic              halted_i,
    input  logic              done_i,
    input  logic              irq_req_i,
    input  logic              bad_kind_i,
    output logic [IDX_W-1:0]  head_o,
    output logic [MEM_AW-1:0] base_o,
    output logic              irq_o
);
    logic [IDX_W-1:0]  head_q;
    logic              head_seen_q;
    logic [MEM_AW-1:0] base_q;
    logic [1:0]        err_q;
    logic              irq_q;
    logic              head_wr, ack_wr, repeat_hit;

    assign head_wr    = reg_wr && (reg_addr == RA_HEAD);
    assign ack_wr     = reg_wr && (reg_addr == RA_STAT) && reg_wdata[2];
    assign repeat_hit = head_wr && head_seen_q && (reg_wdata[IDX_W-1:0] == head_q);

    // Capture head writes and remember that at least one has happened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q      <= '0;
            head_seen_q <= 1'b0;
        end else if (head_wr) begin
            head_q      <= reg_wdata[IDX_W-1:0];
            head_seen_q <= 1'b1;
        end
    end

    // Ring base register.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else if (reg_wr && reg_addr == RA_BASE) base_q <= reg_wdata[MEM_AW-1:0];
    end

    // Sticky error bits: bit 0 is a repeated head write, bit 1 is an unknown kind.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else err_q <= err_q | {bad_kind_i, repeat_hit};
    end

    // Interrupt level: a set request wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else if (done_i && irq_req_i) irq_q <= 1'b1;
        else if (ack_wr) irq_q <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            RA_HEAD: reg_rdata = 32'(head_q);
            RA_TAIL: reg_rdata = 32'(tail_i);
            RA_BASE: reg_rdata = 32'(base_q);
            RA_ERR:  reg_rdata = 32'(err_q);
            RA_STAT: reg_rdata = {29'd0, irq_q, halted_i, busy_i};
            default: reg_rdata = '0;
        endcase
    end

    assign head_o = head_q;
    assign base_o = base_q;
    assign irq_o  = irq_q;

    // R8: the overrun flag never clears once set
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q[0] |=> err_q[0]);
    // R7: the interrupt holds until acknowledged and rises only on a flagged completion
    a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack_wr) |=> irq_q);
    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(done_i && irq_req_i));
endmodule

// File: rtl/dma_ring_engine.sv
// Descriptor engine: fetches both words of a slot, decodes the kind and runs
// a copy or a status write over the shared synchronous memory port.
// Assumes memory read data is valid the cycle after a read request.
module dma_ring_engine
    import dma_ring_pkg::*;
#(
    parameter int IDX_W      = 3,
    parameter int MEM_AW     = 10,
    parameter int LEN_W      = 8,
    parameter int UNIT_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  head_i,
    input  logic [IDX_W-1:0]  tail_i,
    input  logic [MEM_AW-1:0] slot_addr_i,
    output logic              busy_o,
    output logic              halted_o,
    output logic              done_o,
    output logic              irq_req_o,
    output logic              bad_kind_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata
);
    localparam int CNT_W = LEN_W + UNIT_SHIFT;

    eng_state_t        state_q, state_d;
    logic [63:0]       w0_q;
    logic [MEM_AW-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  total_q, idx_q;
    logic              irq_flag_q;
    logic [3:0]        kind;
    logic [LEN_W-1:0]  len_units;

    assign kind      = mem_rdata[KIND_LSB +: 4];
    assign len_units = w0_q[LEN_LSB +: LEN_W];

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (tail_i != head_i) state_d = ST_RD1;
            ST_RD1:   state_d = ST_DEC;
            ST_DEC: begin
                if (kind == KIND_COPY)
                    state_d = (len_units == '0) ? ST_DONE : ST_CP_RD;
                else if (kind == KIND_STAT)
                    state_d = ST_ST_WR;
                else
                    state_d = ST_HALT;
            end
            ST_CP_RD: state_d = ST_CP_WR;
            ST_CP_WR: state_d = (idx_q + 1'b1 == total_q) ? ST_DONE : ST_CP_RD;
            ST_ST_WR: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_HALT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else state_q <= state_d;
    end

    // Descriptor capture and the copy word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w0_q       <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            total_q    <= '0;
            idx_q      <= '0;
            irq_flag_q <= 1'b0;
        end else begin
            if (state_q == ST_RD1) w0_q <= mem_rdata;
            if (state_q == ST_DEC) begin
                src_q      <= w0_q[MEM_AW+2:3];
                dst_q      <= mem_rdata[MEM_AW+2:3];
                total_q    <= {len_units, {UNIT_SHIFT{1'b0}}};
                idx_q      <= '0;
                irq_flag_q <= (kind == KIND_STAT) && mem_rdata[IRQ_BIT];
            end
            if (state_q == ST_CP_WR) idx_q <= idx_q + 1'b1;
        end
    end

    // Memory port drive for each state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_IDLE: begin
                mem_req  = (tail_i != head_i);
                mem_addr = slot_addr_i;
            end
            ST_RD1: begin
                mem_req  = 1'b1;
                mem_addr = slot_addr_i + 1'b1;
            end
            ST_CP_RD: begin
                mem_req  = 1'b1;
                mem_addr = src_q + MEM_AW'(idx_q);
            end
            ST_CP_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q + MEM_AW'(idx_q);
                mem_wdata = mem_rdata;
            end
            ST_ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_wdata = w0_q;
            end
            default: ;
        endcase
    end

    assign done_o     = (state_q == ST_DONE);
    assign irq_req_o  = irq_flag_q;
    assign bad_kind_o = (state_q == ST_DEC) && (kind != KIND_COPY) && (kind != KIND_STAT);
    assign halted_o   = (state_q == ST_HALT);
    assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_HALT);

    // R9: a halted channel stays halted and is silent on the memory port
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> !mem_req);
    a_r9_halt_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> (state_q == ST_HALT));
    // R5: a status descriptor gives exactly one write, then the completion
    a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ST_WR) |=> (state_q == ST_DONE) && !mem_req);
endmodule

// File: rtl/dma_ring_channel.sv
// Top level of the single-channel descriptor-ring DMA.
// Assumes a synchronous memory port with a one-cycle read latency, and a ring of 2**IDX_W slots.
module dma_ring_channel #(
    parameter int IDX_W      = 3,
    parameter int MEM_AW     = 10,
    parameter int LEN_W      = 8,
    parameter int UNIT_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    output logic              irq
);
    logic [IDX_W-1:0]  head, tail;
    logic [MEM_AW-1:0] base, slot_addr;
    logic              busy, halted, done, irq_req, bad_kind;

    dma_ring_regs #(.IDX_W(IDX_W), .MEM_AW(MEM_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tail_i(tail),
        .busy_i(busy), .halted_i(halted), .done_i(done), .irq_req_i(irq_req),
        .bad_kind_i(bad_kind), .head_o(head), .base_o(base), .irq_o(irq)
    );

    dma_ring_tail #(.IDX_W(IDX_W), .MEM_AW(MEM_AW)) u_tail (
        .clk(clk), .rst_n(rst_n), .done_i(done), .base_i(base),
        .tail_o(tail), .slot_addr_o(slot_addr)
    );

    dma_ring_engine #(.IDX_W(IDX_W), .MEM_AW(MEM_AW), .LEN_W(LEN_W),
                      .UNIT_SHIFT(UNIT_SHIFT)) u_engine (
        .clk(clk), .rst_n(rst_n), .head_i(head), .tail_i(tail),
        .slot_addr_i(slot_addr), .busy_o(busy), .halted_o(halted),
        .done_o(done), .irq_req_o(irq_req), .bad_kind_o(bad_kind),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );
endmodule

// File: tb/dma_ring_channel_tb.sv
// Directed bench for dma_ring_channel, with a behavioural synchronous memory.
module dma_ring_channel_tb;
    localparam int MEM_AW = 10;
    localparam int BASE   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mem_req, mem_we, irq;
    logic [MEM_AW-1:0] mem_addr;
    logic [63:0]       mem_wdata;
    logic [63:0]       mem_rdata = '0;
    logic [63:0]       mem [0:(1<<MEM_AW)-1];

    int total = 0;
    int bad = 0;
    int exp_tail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_ring_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    // Synchronous memory model with a one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else mem_rdata <= mem[mem_addr];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [63:0] copy_w0(input int src_w, input int units);
        return (64'(units) << 46) | (64'(src_w) << 3);
    endfunction
    function automatic logic [63:0] copy_w1(input int dst_w);
        return (64'd1 << 60) | (64'(dst_w) << 3);
    endfunction
    function automatic logic [63:0] stat_w1(input int dst_w, input bit flag);
        return (64'd2 << 60) | (64'(flag) << 59) | (64'(dst_w) << 3);
    endfunction

    task automatic put_desc(input int slot, input logic [63:0] w0, input logic [63:0] w1);
        mem[BASE + 2*slot]     = w0;
        mem[BASE + 2*slot + 1] = w1;
    endtask

    task automatic wait_tail(input int target, input string tag);
        logic [31:0] t;
        bit hit = 0;
        for (int i = 0; i < 3000 && !hit; i++) begin
            reg_read(3'd1, t);
            if (t == 32'(target)) hit = 1;
        end
        check(hit, {tag, " tail reaches head"}, 64'(t), 64'(target));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        reg_read(3'd0, d); check(d == 0, "R1 head after reset", 64'(d), 0);
        reg_read(3'd1, d); check(d == 0, "R1 tail after reset", 64'(d), 0);
        reg_read(3'd3, d); check(d == 0, "R1 error after reset", 64'(d), 0);
        reg_read(3'd4, d); check(d == 0, "R1 status after reset", 64'(d), 0);
        check(irq == 0, "R1 irq after reset", 64'(irq), 0);
        reg_write(3'd2, BASE);
        reg_read(3'd2, d); check(d == BASE, "R10 base readback", 64'(d), BASE);
    endtask

    task automatic t_status_irq;
        logic [31:0] d;
        put_desc(0, 64'hCAFE_F00D_1234_5678, stat_w1(500, 1'b1));
        reg_write(3'd0, 1);
        exp_tail = 1;
        wait_tail(1, "R2");
        check(mem[500] == 64'hCAFE_F00D_1234_5678, "R5 status value", mem[500], 64'hCAFE_F00D_1234_5678);
        check(irq == 1, "R7 irq raised", 64'(irq), 1);
        repeat (5) @(negedge clk);
        check(irq == 1, "R7 irq held", 64'(irq), 1);
        reg_read(3'd4, d); check(d[2] == 1, "R10 status irq bit", 64'(d), 4);
        reg_write(3'd4, 32'h4);
        #1 check(irq == 0, "R7 irq acknowledged", 64'(irq), 0);
    endtask

    task automatic t_status_noirq;
        put_desc(1, 64'h0BAD_BEEF_0000_0011, stat_w1(501, 1'b0));
        reg_write(3'd0, 2);
        exp_tail = 2;
        wait_tail(2, "R6");
        check(mem[501] == 64'h0BAD_BEEF_0000_0011, "R5 second status", mem[501], 64'h0BAD_BEEF_0000_0011);
        check(irq == 0, "R7 no irq without flag", 64'(irq), 0);
    endtask

    task automatic t_copy;
        bit ok = 1;
        for (int i = 0; i < 16; i++) mem[100+i] = 64'hA5A5_0000_0000_0000 + 64'(i);
        mem[316] = 64'h5E17;
        put_desc(2, copy_w0(100, 2), copy_w1(300));
        reg_write(3'd0, 3);
        wait_tail(3, "R3");
        for (int i = 0; i < 16; i++)
            if (mem[300+i] != 64'hA5A5_0000_0000_0000 + 64'(i)) ok = 0;
        check(ok, "R3 sixteen words copied", mem[315], 64'hA5A5_0000_0000_000F);
        check(mem[316] == 64'h5E17, "R3 no write past end", mem[316], 64'h5E17);
    endtask

    task automatic t_copy_zero;
        mem[400] = 64'h7777;
        put_desc(3, copy_w0(100, 0), copy_w1(400));
        reg_write(3'd0, 4);
        wait_tail(4, "R4");
        check(mem[400] == 64'h7777, "R4 zero length writes nothing", mem[400], 64'h7777);
    endtask

    task automatic t_batch_wrap;
        logic [31:0] d;
        bit ok = 1;
        for (int k = 0; k < 6; k++) put_desc((4 + k) % 8, 64'h100 + 64'(k), stat_w1(600 + k, 1'b0));
        reg_write(3'd0, 2);
        wait_tail(2, "R6 wrap");
        for (int k = 0; k < 6; k++) if (mem[600+k] != 64'h100 + 64'(k)) ok = 0;
        check(ok, "R6 batch across wrap", mem[605], 64'h105);
        reg_read(3'd3, d); check(d == 0, "R8 distinct head writes not flagged", 64'(d), 0);
        reg_read(3'd4, d); check(d[0] == 0, "R10 idle after batch", 64'(d), 0);
    endtask

    task automatic t_head_repeat;
        logic [31:0] d;
        reg_write(3'd0, 2);
        reg_read(3'd3, d); check(d[0] == 1, "R8 repeated head flagged", 64'(d), 1);
        repeat (10) @(negedge clk);
        reg_read(3'd1, d); check(d == 2, "R8 tail unchanged", 64'(d), 2);
    endtask

    task automatic t_bad_kind;
        logic [31:0] d;
        mem[700] = 64'h9999;
        put_desc(2, 64'h1, (64'd3 << 60) | (64'd700 << 3));
        reg_write(3'd0, 3);
        repeat (20) @(negedge clk);
        reg_read(3'd4, d); check(d[1:0] == 2'b10, "R9 quiesce shown", 64'(d), 2);
        reg_read(3'd3, d); check(d[1] == 1, "R9 kind error bit", 64'(d), 3);
        reg_read(3'd1, d); check(d == 2, "R9 tail not advanced", 64'(d), 2);
        check(mem[700] == 64'h9999, "R9 no write", mem[700], 64'h9999);
        check(mem_req == 0, "R9 memory silent", 64'(mem_req), 0);
    endtask

    initial begin
        for (int i = 0; i < (1<<MEM_AW); i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status_irq();
        t_status_noirq();
        t_copy();
        t_copy_zero();
        t_batch_wrap();
        t_head_repeat();
        t_bad_kind();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule